// File: doc/BRIEF.md
# Privileged comparator value register bank

This block holds up to eight 64-bit comparator value registers that software reaches through a system-register style instruction interface. On each cycle it looks at the encoding fields of the instruction (op0, op1, CRn, CRm and op2) and at the direction of the transfer. When the encoding addresses this bank, it selects one register from the CRm field. It then decides whether the access is undefined, traps to a higher privilege level, or goes ahead.

The decision uses the current privilege level and one trap-enable control for each of levels 1, 2 and 3. Two qualifiers, whether level 2 is enabled and whether level 3 is present, each combined with a 64-bit-state flag, decide whether the level-2 and level-3 controls take part. A successful read returns the stored value in the same cycle. A successful write takes effect at the next clock edge. Two parameters set how many registers exist and how many low value bits are kept. The logic that compares against these values, and exception entry, belong to other blocks.

Top module: `cmpval_sysreg_bank`

## Requirements
- R1: An access addresses the bank only when acc_valid is 1, op0=2'b10, op1=3'b001, CRn=4'b0011, op2=3'b001 and CRm bit 0 is 0. The register index is CRm[3:1]. When the access does not address the bank, res_ok, res_undef, res_trap, trap_el, trap_class and rdata are all zero and no register changes.
- R2: An addressed access made at level 0 (cur_el=2'd0) always gives res_undef.
- R3: At levels 1 to 3, an addressed access whose index is NUM_REGS or more gives res_undef. This check comes before any trap check.
- R4: At level 1 the checks run in this order: el1_trap_en traps to level 1; then el2_trap_en traps to level 2 when el2_enabled and el2_is64 are both 1; then el3_trap_en traps to level 3 when el3_present and el3_is64 are both 1. If none of these fires, the access succeeds.
- R5: At level 2, el2_trap_en traps to level 2 whatever the level-2 qualifiers are. Otherwise el3_trap_en traps to level 3 when el3_present and el3_is64 are both 1. Otherwise the access succeeds.
- R6: At level 3, only el3_trap_en is checked. When it is set the access traps to level 3; otherwise it succeeds.
- R7: At most one of res_ok, res_undef and res_trap is high. A trap drives trap_class to 6'h18 and trap_el to the target level. When there is no trap, both trap_el and trap_class are zero.
- R8: A successful read returns the selected register, zero-extended to 64 bits, on rdata in the same cycle. A successful write updates the selected register at the next rising clock edge. A read in the cycle after a write returns the new value.
- R9: Only the low VAL_W bits of each register are kept. On rdata, bits VAL_W and above are always zero, and write data in those bits has no effect.
- R10: An undefined, trapped or unaddressed access leaves every register unchanged. Every result other than a successful read gives rdata equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low trace-unit reset; writes are blocked while it is low |
| acc_valid | input | 1 | A system-register access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm; [3:1] is the index, [0] must be 0 |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| el1_trap_en | input | 1 | Level-1 trace access trap control |
| el2_trap_en | input | 1 | Level-2 trace access trap control |
| el3_trap_en | input | 1 | Level-3 trace access trap control |
| el2_enabled | input | 1 | Level 2 is enabled |
| el2_is64 | input | 1 | Level 2 uses the 64-bit state |
| el3_present | input | 1 | Level 3 is implemented |
| el3_is64 | input | 1 | Level 3 uses the 64-bit state |
| res_ok | output | 1 | The access succeeds |
| res_undef | output | 1 | The access is an undefined instruction |
| res_trap | output | 1 | The access traps |
| trap_el | output | 2 | Target level of the trap, zero when there is no trap |
| trap_class | output | 6 | Syndrome class of the trap, zero when there is no trap |
| rdata | output | 64 | Read data, zero unless a read succeeds |

## Verification
The assertions check on every cycle the properties that do not depend on stored state:

- the result flags are mutually exclusive;
- level 0 never succeeds or traps;
- a trap carries class 6'h18 and targets a level no lower than the current one, and trap_el and trap_class are quiet otherwise;
- nothing answers without a valid access;
- rdata is zero outside a successful read and never has a bit set above the implemented width.

The priority order of the trap chains is shown only by the bench. It sweeps every level, every combination of the seven controls, every index and both directions, and compares each result with a model. The bench's scenarios also show that writes land one edge later and that rejected writes leave the registers unchanged, by reading back a shadow copy of the registers.

// File: rtl/cmpval_sysreg_bank.sv
module cmpval_sysreg_bank #(
  parameter int NUM_REGS = 8,
  parameter int VAL_W    = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_op0,
  input  logic [2:0]  acc_op1,
  input  logic [3:0]  acc_crn,
  input  logic [3:0]  acc_crm,
  input  logic [2:0]  acc_op2,
  input  logic [63:0] acc_wdata,
  input  logic [1:0]  cur_el,
  input  logic        el1_trap_en,
  input  logic        el2_trap_en,
  input  logic        el3_trap_en,
  input  logic        el2_enabled,
  input  logic        el2_is64,
  input  logic        el3_present,
  input  logic        el3_is64,
  output logic        res_ok,
  output logic        res_undef,
  output logic        res_trap,
  output logic [1:0]  trap_el,
  output logic [5:0]  trap_class,
  output logic [63:0] rdata
);

  localparam int          DATA_W   = 64;
  localparam int          IDX_W    = 3;
  localparam logic [3:0]  NUM_LIM  = 4'(NUM_REGS);
  localparam logic [5:0]  TRAP_EC  = 6'h18;
  localparam logic [DATA_W-1:0] VAL_MASK =
    (VAL_W >= DATA_W) ? '1 : ((64'd1 << VAL_W) - 64'd1);

  logic             enc_hit;
  logic [IDX_W-1:0] idx;
  logic             idx_exists;
  logic             is_undef;
  logic             trap_go;
  logic [1:0]       trap_tgt;
  logic             wr_en;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] reg_rd [NUM_REGS];

  assign enc_hit = acc_valid && acc_op0 == 2'b10 && acc_op1 == 3'b001 &&
                   acc_crn == 4'b0011 && acc_op2 == 3'b001 && !acc_crm[0];
  assign idx        = acc_crm[3:1];
  assign idx_exists = {1'b0, idx} < NUM_LIM;
  assign is_undef   = (cur_el == 2'd0) || !idx_exists;

  always_comb begin
    trap_go  = 1'b0;
    trap_tgt = 2'd0;
    case (cur_el)
      2'd1: begin
        if (el1_trap_en) begin
          trap_go = 1'b1; trap_tgt = 2'd1;
        end else if (el2_enabled && el2_is64 && el2_trap_en) begin
          trap_go = 1'b1; trap_tgt = 2'd2;
        end else if (el3_present && el3_is64 && el3_trap_en) begin
          trap_go = 1'b1; trap_tgt = 2'd3;
        end
      end
      2'd2: begin
        if (el2_trap_en) begin
          trap_go = 1'b1; trap_tgt = 2'd2;
        end else if (el3_present && el3_is64 && el3_trap_en) begin
          trap_go = 1'b1; trap_tgt = 2'd3;
        end
      end
      2'd3: begin
        if (el3_trap_en) begin
          trap_go = 1'b1; trap_tgt = 2'd3;
        end
      end
      default: ;
    endcase
  end

  assign res_undef  = enc_hit && is_undef;
  assign res_trap   = enc_hit && !is_undef && trap_go;
  assign res_ok     = enc_hit && !is_undef && !trap_go;
  assign trap_el    = res_trap ? trap_tgt : 2'd0;
  assign trap_class = res_trap ? TRAP_EC : 6'd0;
  assign wr_en      = res_ok && acc_write && rst_n;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (wr_en && idx == IDX_W'(g))
        val_q <= acc_wdata & VAL_MASK;
    end
    assign reg_rd[g] = val_q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rd_val = reg_rd[i];
  end

  assign rdata = (res_ok && !acc_write) ? (rd_val & VAL_MASK) : '0;

endmodule

// File: rtl/cmpval_sysreg_bank_chk.sv
module cmpval_sysreg_bank_chk #(
  parameter int VAL_W = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  cur_el,
  input logic        res_ok,
  input logic        res_undef,
  input logic        res_trap,
  input logic [1:0]  trap_el,
  input logic [5:0]  trap_class,
  input logic [63:0] rdata
);

  localparam logic [63:0] HI_MASK =
    (VAL_W >= 64) ? 64'd0 : ~((64'd1 << VAL_W) - 64'd1);

  assert_result_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_ok, res_undef, res_trap}));

  assert_no_answer_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(res_ok || res_undef || res_trap));

  assert_el0_undefined_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_el == 2'd0 |-> !(res_ok || res_trap));

  assert_trap_syndrome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_trap |-> trap_class == 6'h18 && trap_el != 2'd0 && trap_el >= cur_el);

  assert_quiet_without_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_trap |-> trap_el == 2'd0 && trap_class == 6'd0);

  assert_el3_self_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_trap && cur_el == 2'd3 |-> trap_el == 2'd3);

  assert_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_ok && !acc_write) |-> rdata == 64'd0);

  assert_hi_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & HI_MASK) == 64'd0);

endmodule

bind cmpval_sysreg_bank cmpval_sysreg_bank_chk #(.VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .cur_el     (cur_el),
  .res_ok     (res_ok),
  .res_undef  (res_undef),
  .res_trap   (res_trap),
  .trap_el    (trap_el),
  .trap_class (trap_class),
  .rdata      (rdata)
);

// File: tb/cmpval_sysreg_bank_bench.sv
`timescale 1ns/1ps
module cmpval_sysreg_bank_bench;

  localparam int          NR   = 6;
  localparam int          VW   = 16;
  localparam logic [63:0] MASK = (64'd1 << VW) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_op0 = '0;
  logic [2:0]  acc_op1 = '0;
  logic [3:0]  acc_crn = '0, acc_crm = '0;
  logic [2:0]  acc_op2 = '0;
  logic [63:0] acc_wdata = '0;
  logic [1:0]  cur_el = '0;
  logic        el1_trap_en = 0, el2_trap_en = 0, el3_trap_en = 0;
  logic        el2_enabled = 0, el2_is64 = 0, el3_present = 0, el3_is64 = 0;
  logic        res_ok, res_undef, res_trap;
  logic [1:0]  trap_el;
  logic [5:0]  trap_class;
  logic [63:0] rdata;

  int n_cmp = 0, n_bad = 0, k = 0;
  bit done = 0;
  logic [63:0] shadow [8];
  bit known [8];

  always #10 clk = ~clk;

  cmpval_sysreg_bank #(.NUM_REGS(NR), .VAL_W(VW)) u_cmpval_sysreg_bank (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_op2(acc_op2), .acc_wdata(acc_wdata), .cur_el(cur_el),
    .el1_trap_en(el1_trap_en), .el2_trap_en(el2_trap_en), .el3_trap_en(el3_trap_en),
    .el2_enabled(el2_enabled), .el2_is64(el2_is64), .el3_present(el3_present),
    .el3_is64(el3_is64), .res_ok(res_ok), .res_undef(res_undef), .res_trap(res_trap),
    .trap_el(trap_el), .trap_class(trap_class), .rdata(rdata)
  );

  // ctl: [0] t1, [1] t2, [2] t3, [3] el2 enabled, [4] el2 64-bit, [5] el3 present, [6] el3 64-bit
  task automatic access(input bit w, input logic [1:0] el, input logic [6:0] ctl,
                        input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn,
                        input logic [3:0] cm, input logic [2:0] o2, input logic [63:0] wd);
    int kind; logic [1:0] tgt; logic [2:0] ix; bit match; bit rd_chk;
    logic [63:0] er; logic [10:0] es, gs; string tg;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_op0 = o0; acc_op1 = o1; acc_crn = cn;
    acc_crm = cm; acc_op2 = o2; acc_wdata = wd; cur_el = el;
    {el3_is64, el3_present, el2_is64, el2_enabled, el3_trap_en, el2_trap_en, el1_trap_en} = ctl;
    #2;
    ix = cm[3:1];
    match = o0 == 2'b10 && o1 == 3'b001 && cn == 4'b0011 && o2 == 3'b001 && !cm[0];
    tgt = 2'd0; kind = 0; tg = "R1";
    if (match) begin
      if (el == 2'd0) begin kind = 2; tg = "R2"; end
      else if (int'(ix) >= NR) begin kind = 2; tg = "R3"; end
      else begin
        case (el)
          2'd1: begin
            tg = "R4";
            if (ctl[0]) tgt = 2'd1;
            else if (ctl[3] && ctl[4] && ctl[1]) tgt = 2'd2;
            else if (ctl[5] && ctl[6] && ctl[2]) tgt = 2'd3;
          end
          2'd2: begin
            tg = "R5";
            if (ctl[1]) tgt = 2'd2;
            else if (ctl[5] && ctl[6] && ctl[2]) tgt = 2'd3;
          end
          default: begin
            tg = "R6";
            if (ctl[2]) tgt = 2'd3;
          end
        endcase
        kind = (tgt != 2'd0) ? 3 : 1;
        if (kind == 1) tg = "R8";
      end
    end
    es = {kind == 1, kind == 2, kind == 3, tgt, (kind == 3) ? 6'h18 : 6'h00};
    gs = {res_ok, res_undef, res_trap, trap_el, trap_class};
    rd_chk = !(kind == 1 && !w && !known[ix]);
    er = (kind == 1 && !w) ? shadow[ix] : 64'd0;
    n_cmp++;
    if (es !== gs || (rd_chk && rdata !== er)) begin
      n_bad++;
      $display("FAIL %s (R7/R10 flags+rdata) el=%0d ctl=%b idx=%0d w=%0d: got %b rdata=%h, expected %b rdata=%h",
               tg, el, ctl, ix, w, gs, rdata, es, er);
    end
    if (kind == 1 && w) begin shadow[ix] = wd & MASK; known[ix] = 1'b1; end
  endtask

  task automatic good(input bit w, input logic [1:0] el, input logic [6:0] ctl,
                      input logic [2:0] ix, input logic [63:0] wd);
    access(w, el, ctl, 2'b10, 3'b001, 4'b0011, {ix, 1'b0}, 3'b001, wd);
  endtask

  function automatic logic [63:0] pat(input int n);
    return 64'(n + 1) * 64'h9E37_79B9_7F4A_7C15;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin shadow[i] = '0; known[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if ({res_ok, res_undef, res_trap, trap_el, trap_class} !== 11'd0 || rdata !== 64'd0) begin
      n_bad++;
      $display("FAIL R1 reset idle: got flags=%b rdata=%h, expected 0 and 0",
               {res_ok, res_undef, res_trap, trap_el, trap_class}, rdata);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NR; i++) good(1'b1, 2'd3, 7'd0, 3'(i), pat(k++));
    for (int i = 0; i < NR; i++) good(1'b0, 2'd3, 7'd0, 3'(i), 64'd0);

    // full sweep of levels, controls, indices and directions (R2..R8, R10)
    for (int el = 0; el < 4; el++)
      for (int c = 0; c < 128; c++)
        for (int ix = 0; ix < 8; ix++)
          for (int w = 0; w < 2; w++)
            good(w[0], 2'(el), 7'(c), 3'(ix), pat(k++));

    // R8: write, then read in the next cycle
    good(1'b1, 2'd1, 7'd0, 3'd2, 64'h0000_0000_0000_3C5A);
    good(1'b0, 2'd1, 7'd0, 3'd2, 64'd0);
    // R9: bits above the width are dropped
    good(1'b1, 2'd2, 7'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    good(1'b0, 2'd2, 7'd0, 3'd0, 64'd0);

    // R1: one wrong field at a time, each a write that must be ignored
    for (int v = 0; v < 4; v++)
      if (v != 2) access(1'b1, 2'd3, 7'd0, 2'(v), 3'b001, 4'b0011, 4'b0010, 3'b001, 64'hDEAD_BEEF_CAFE_F00D);
    for (int v = 0; v < 8; v++)
      if (v != 1) access(1'b1, 2'd3, 7'd0, 2'b10, 3'(v), 4'b0011, 4'b0010, 3'b001, 64'h1111_2222_3333_4444);
    for (int v = 0; v < 16; v++)
      if (v != 3) access(1'b1, 2'd3, 7'd0, 2'b10, 3'b001, 4'(v), 4'b0100, 3'b001, 64'h5555_6666_7777_8888);
    for (int v = 0; v < 8; v++)
      if (v != 1) access(1'b1, 2'd3, 7'd0, 2'b10, 3'b001, 4'b0011, 4'b0110, 3'(v), 64'h9999_AAAA_BBBB_CCCC);
    for (int v = 0; v < 8; v++)
      access(1'b1, 2'd3, 7'd0, 2'b10, 3'b001, 4'b0011, {3'(v), 1'b1}, 3'b001, 64'hABCD_EF01_2345_6789);

    // R10: contents survive all rejected accesses
    for (int i = 0; i < NR; i++) good(1'b0, 2'd3, 7'd0, 3'(i), 64'd0);

    @(negedge clk);
    acc_valid = 1'b0;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule